// File: doc/BRIEF.md
# External memory bus strobe generator

This block produces the address-latch strobe (ALE) and the active-low program-read strobe (PSEN) for the multiplexed external memory bus of an 8-bit controller. It runs from the oscillator-rate clock. A divide-by-two phase flip-flop splits each machine state into two phases, so the input duty cycle does not matter. A six-state machine (ST_S1 to ST_S6) steps once every two oscillator clocks, which gives a machine cycle of 12 oscillator clocks. Both the state index and the phase are brought out. The only way a state changes is the step from phase 1 to the next state: ST_S1→ST_S2, ST_S2→ST_S3, ST_S3→ST_S4, ST_S4→ST_S5, ST_S5→ST_S6 and ST_S6→ST_S1. The last of these is the machine-cycle boundary. Internal reset forces ST_S1, phase 0 from any state.

ALE pulses in phase 0 of ST_S1 and of ST_S4. PSEN goes low in phase 1 of those same states, so the two strobes never overlap. A machine cycle flagged as an external data access loses its ST_S4 ALE pulse and both of its PSEN activations. Software can disable ALE through a register write, and the weak-pull-high indicator is then raised. This disable is suspended during external data cycles and code-constant read cycles, and while the idle or power-down mode flag is high. It has no effect when the latched strap selects external program execution.

A raw reset pin passes through a synchroniser. The block recognises internal reset only after the pin has stayed high for two full machine cycles. The external-access strap is sampled while reset is active.

Top module: `bus_strobe_gen`

## Requirements
- R1: `phase` alternates 0,1 on every oscillator clock. `state_idx` (0..5 encodes ST_S1..ST_S6) changes only after phase 1, steps by one and wraps from 5 to 0. A machine cycle is therefore 12 clocks.
- R2: With no external data access and no effective disable, `ale` is high in phase 0 of ST_S1 and of ST_S4 only. That is two one-clock pulses per machine cycle, at one sixth of the clock rate.
- R3: `xdata_cyc` is sampled on the clock edge that leaves ST_S6 phase 1, and it applies to the machine cycle that begins there. In such a cycle the ST_S4 ALE pulse is omitted and the ST_S1 pulse remains.
- R4: With external execution latched, `psen_n` is low in phase 1 of ST_S1 and of ST_S4 only. `psen_n` is never low while `ale` is high.
- R5: `psen_n` stays high for the whole of an external data cycle, and at all times when internal execution is latched.
- R6: A write (`reg_we`=1) to address 8'h87 loads data bit 5 into the ALE-disable bit. While that bit is effective, `ale` stays low and `ale_weak` is high. Writes to other addresses, and the other data bits, have no effect on it.
- R7: The disable is suspended in cycles flagged by `xdata_cyc` or `code_cyc` (both sampled as in R3), and while `idle_mode` or `pdown_mode` is high. While it is suspended, ALE behaves as in R2/R3 and `ale_weak` is low.
- R8: When `strap_ext`=1 is latched (external program execution), the disable bit has no effect: ALE pulses normally and `ale_weak` stays low.
- R9: `rst_int` rises only after `rst_pin` has been high for 24 consecutive clocks, seen after a two-stage synchroniser. A pulse of 16 clocks is ignored. `rst_int` falls within 3 clocks after the pin goes low.
- R10: While `rst_int` is high, the outputs are `state_idx`=0, `phase`=0, `ale`=0, `psen_n`=1 and `ale_weak`=0, and the disable bit is cleared. `strap_ext` is latched during reset and held until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator-rate clock |
| rst_pin | input | 1 | Raw asynchronous reset pin, active high |
| xdata_cyc | input | 1 | Next machine cycle is an external data access |
| code_cyc | input | 1 | Next machine cycle is a code-constant read |
| idle_mode | input | 1 | Idle mode active |
| pdown_mode | input | 1 | Power-down mode active |
| strap_ext | input | 1 | External-access strap, 1 = execute from external memory |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| ale | output | 1 | Address latch strobe, active high |
| ale_weak | output | 1 | ALE held by weak pull-high |
| psen_n | output | 1 | Program-read strobe, active low |
| state_idx | output | 3 | Machine state 0..5 (ST_S1..ST_S6) |
| phase | output | 1 | Phase within the state |
| rst_int | output | 1 | Qualified, synchronised internal reset |

## Verification
Several properties are checked on every cycle. The phase toggles, and the state holds across phase 0. ALE and PSEN never overlap. An active weak pull excludes an ALE pulse. Internal execution keeps PSEN high. The latched strap stays fixed outside reset, and internal reset rises only with a full qualification count. Pulse counts per machine cycle can only be shown by the bench's scenarios. These cover the skipped ALE and PSEN strobes in external data cycles, disable versus suspension versus external execution, ignored register writes, short reset pulses, and a strap changed after reset.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
    localparam int MC_STATES = 6;
    localparam int MC_PHASES = 2;

    typedef enum logic [2:0] {
        ST_S1 = 3'd0,
        ST_S2 = 3'd1,
        ST_S3 = 3'd2,
        ST_S4 = 3'd3,
        ST_S5 = 3'd4,
        ST_S6 = 3'd5
    } mstate_t;
endpackage

// File: rtl/rst_qual.sv
module rst_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CLKS   = 24
) (
    input  logic clk,
    input  logic pin,
    output logic rst_o
);
    localparam int CW = $clog2(HOLD_CLKS + 1);

    logic          pin_hi;
    logic [CW-1:0] hi_cnt;
    logic          rst_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            logic s_q;
            always_ff @(posedge clk) s_q <= pin;
            assign pin_hi = s_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk) s_q <= {s_q[SYNC_STAGES-2:0], pin};
            assign pin_hi = s_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!pin_hi)
            hi_cnt <= '0;
        else if (hi_cnt != CW'(HOLD_CLKS))
            hi_cnt <= hi_cnt + CW'(1);
        rst_q <= pin_hi && (hi_cnt >= CW'(HOLD_CLKS - 1));
    end

    assign rst_o = rst_q;

    AST_RST_QUALIFIED: assert property (@(posedge clk) $rose(rst_q) |-> hi_cnt == CW'(HOLD_CLKS)); // R9
    AST_RST_RELEASE: assert property (@(posedge clk) !pin_hi |=> !rst_q); // R9
endmodule

// File: rtl/cycle_seq.sv
module cycle_seq
    import strobe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    output mstate_t st_o,
    output logic    ph_o,
    output logic    last_o
);
    mstate_t st_q, st_nx;
    logic    ph_q;

    // state register: phase flip-flop divides the clock by two
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_S1;
            ph_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
            if (ph_q)
                st_q <= st_nx;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_S1:   st_nx = ST_S2;
            ST_S2:   st_nx = ST_S3;
            ST_S3:   st_nx = ST_S4;
            ST_S4:   st_nx = ST_S5;
            ST_S5:   st_nx = ST_S6;
            ST_S6:   st_nx = ST_S1;
            default: st_nx = ST_S1;
        endcase
    end

    assign st_o   = st_q;
    assign ph_o   = ph_q;
    assign last_o = (st_q == ST_S6) && ph_q;

    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst) !rst |=> ph_q != $past(ph_q)); // R1
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst) (!rst && !ph_q) |=> $stable(st_q)); // R1
endmodule

// File: rtl/strobe_out.sv
module strobe_out
    import strobe_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  DIS_ADDR = 8'h87,
    parameter int          DIS_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  mstate_t           st,
    input  logic              ph,
    input  logic              last,
    input  logic              xdata_req,
    input  logic              code_req,
    input  logic              idle,
    input  logic              pdown,
    input  logic              strap,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ale,
    output logic              ale_weak,
    output logic              psen_n
);
    localparam logic [DATA_W-1:0] DIS_MASK = DATA_W'(1) << DIS_BIT;

    logic cyc_x, cyc_c, dis_bit, ext_lat;
    logic slot_ale, slot_psen, suspend, dis_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_x   <= 1'b0;
            cyc_c   <= 1'b0;
            dis_bit <= 1'b0;
            ext_lat <= strap;
        end else begin
            if (last) begin
                cyc_x <= xdata_req;
                cyc_c <= code_req;
            end
            if (we && addr == ADDR_W'(DIS_ADDR))
                dis_bit <= |(wdata & DIS_MASK);
        end
    end

    // strobe slots within the machine cycle
    always_comb begin
        slot_ale  = 1'b0;
        slot_psen = 1'b0;
        unique case (st)
            ST_S1: begin
                slot_ale  = !ph;
                slot_psen = ph;
            end
            ST_S4: begin
                slot_ale  = !ph && !cyc_x;
                slot_psen = ph;
            end
            default: ;
        endcase
    end

    assign suspend  = cyc_x || cyc_c || idle || pdown;
    assign dis_eff  = dis_bit && !ext_lat && !suspend;
    assign ale      = !rst && slot_ale && !dis_eff;
    assign ale_weak = !rst && dis_eff;
    assign psen_n   = !(!rst && ext_lat && !cyc_x && slot_psen);

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(ale && !psen_n)); // R4
    AST_INT_NO_PSEN: assert property (@(posedge clk) disable iff (rst) !ext_lat |-> psen_n); // R5
    AST_WEAK_NO_ALE: assert property (@(posedge clk) disable iff (rst) ale_weak |-> !ale); // R6
    AST_EXT_NO_WEAK: assert property (@(posedge clk) disable iff (rst) ext_lat |-> !ale_weak); // R8
    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst) !rst |=> $stable(ext_lat)); // R10
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import strobe_pkg::*;
#(
    parameter int         RST_MCYC    = 2,
    parameter int         SYNC_STAGES = 2,
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 8,
    parameter logic [7:0] DIS_ADDR    = 8'h87,
    parameter int         DIS_BIT     = 5
) (
    input  logic              osc_clk,
    input  logic              rst_pin,
    input  logic              xdata_cyc,
    input  logic              code_cyc,
    input  logic              idle_mode,
    input  logic              pdown_mode,
    input  logic              strap_ext,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              ale,
    output logic              ale_weak,
    output logic              psen_n,
    output logic [2:0]        state_idx,
    output logic              phase,
    output logic              rst_int
);
    localparam int HOLD_CLKS = RST_MCYC * MC_STATES * MC_PHASES;

    logic    rst_w, ph_w, last_w;
    mstate_t st_w;

    rst_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CLKS(HOLD_CLKS)) u_rst (
        .clk(osc_clk), .pin(rst_pin), .rst_o(rst_w)
    );

    cycle_seq u_seq (
        .clk(osc_clk), .rst(rst_w), .st_o(st_w), .ph_o(ph_w), .last_o(last_w)
    );

    strobe_out #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIS_ADDR(DIS_ADDR), .DIS_BIT(DIS_BIT)
    ) u_out (
        .clk(osc_clk), .rst(rst_w), .st(st_w), .ph(ph_w), .last(last_w),
        .xdata_req(xdata_cyc), .code_req(code_cyc), .idle(idle_mode),
        .pdown(pdown_mode), .strap(strap_ext), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .ale(ale), .ale_weak(ale_weak), .psen_n(psen_n)
    );

    assign state_idx = st_w;
    assign phase     = ph_w;
    assign rst_int   = rst_w;
endmodule

// File: tb/test_bus_strobe_gen.sv
module test_bus_strobe_gen;
    logic       osc_clk = 1'b0;
    logic       rst_pin = 1'b0;
    logic       xdata_cyc = 1'b0, code_cyc = 1'b0, idle_mode = 1'b0, pdown_mode = 1'b0;
    logic       strap_ext = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic       ale, ale_weak, psen_n, phase, rst_int;
    logic [2:0] state_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bus_strobe_gen i_bus_strobe_gen (
        .osc_clk(osc_clk), .rst_pin(rst_pin), .xdata_cyc(xdata_cyc), .code_cyc(code_cyc),
        .idle_mode(idle_mode), .pdown_mode(pdown_mode), .strap_ext(strap_ext),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ale(ale), .ale_weak(ale_weak), .psen_n(psen_n),
        .state_idx(state_idx), .phase(phase), .rst_int(rst_int)
    );

    always #5 osc_clk = ~osc_clk;

    // row: [10] disable bit, [9] xdata, [8] code, [7] idle, [6] pdown, [5:4] ALE pulses, [3:0] weak clocks
    localparam logic [10:0] VEC [8] = '{
        11'b0_0000_10_0000,
        11'b0_1000_01_0000,
        11'b1_0000_00_1100,
        11'b1_1000_01_0000,
        11'b1_0100_10_0000,
        11'b1_0010_10_0000,
        11'b1_0001_10_0000,
        11'b0_0100_10_0000
    };

    function automatic string vtag(int i);
        case (i)
            0:       return "R2";
            1:       return "R3";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, int got, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    task automatic write_reg(logic [7:0] a, logic [7:0] d);
        @(negedge osc_clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge osc_clk);
        reg_we = 1'b0;
    endtask

    // flags apply to the machine cycle after the one in which they are set
    task automatic run_cycle(logic xd, logic cd, logic idl, logic pd,
                             output int n_ale, output int n_psen, output int n_weak,
                             output int n_seq, output int n_ovl);
        n_ale = 0; n_psen = 0; n_weak = 0; n_seq = 0; n_ovl = 0;
        @(negedge osc_clk);
        while (!(state_idx == 3'd0 && phase == 1'b0)) @(negedge osc_clk);
        xdata_cyc = xd; code_cyc = cd; idle_mode = idl; pdown_mode = pd;
        repeat (12) @(negedge osc_clk);
        for (int j = 0; j < 12; j++) begin
            if (ale) n_ale++;
            if (!psen_n) n_psen++;
            if (ale_weak) n_weak++;
            if (ale && !psen_n) n_ovl++;
            if (state_idx != 3'(j / 2) || phase != 1'(j % 2)) n_seq++;
            if (j != 11) @(negedge osc_clk);
        end
        xdata_cyc = 1'b0; code_cyc = 1'b0; idle_mode = 1'b0; pdown_mode = 1'b0;
    endtask

    task automatic do_reset(logic ext);
        @(negedge osc_clk);
        strap_ext = ext;
        rst_pin = 1'b1;
        repeat (30) @(negedge osc_clk);
        check(rst_int == 1'b1, "R9", "rst_int after 30 clocks", int'(rst_int), 1);
        check(state_idx == 3'd0 && phase == 1'b0 && !ale && psen_n && !ale_weak, "R10",
              "reset outputs {st,ph,ale,psen_n,weak}",
              int'({state_idx, phase, ale, psen_n, ale_weak}), int'({3'd0, 1'b0, 1'b0, 1'b1, 1'b0}));
        rst_pin = 1'b0;
        repeat (5) @(negedge osc_clk);
        check(rst_int == 1'b0, "R9", "rst_int after release", int'(rst_int), 0);
    endtask

    initial begin
        int na, np, nw, ns, no;
        int seen;
        repeat (4) @(negedge osc_clk);
        do_reset(1'b0);

        // table walk, internal execution
        for (int i = 0; i < 8; i++) begin
            write_reg(8'h87, VEC[i][10] ? 8'h20 : 8'h00);
            run_cycle(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], na, np, nw, ns, no);
            check(na == int'(VEC[i][5:4]), vtag(i), $sformatf("vec %0d ALE pulses", i), na, int'(VEC[i][5:4]));
            check(nw == int'(VEC[i][3:0]), vtag(i), $sformatf("vec %0d weak clocks", i), nw, int'(VEC[i][3:0]));
            check(np == 0, "R5", $sformatf("vec %0d PSEN internal", i), np, 0);
            check(ns == 0, "R1", $sformatf("vec %0d state/phase mismatches", i), ns, 0);
        end

        // R6: wrong address and other bits ignored
        write_reg(8'h87, 8'h20);
        write_reg(8'h88, 8'h00);
        run_cycle(0, 0, 0, 0, na, np, nw, ns, no);
        check(nw == 12 && na == 0, "R6", "other address ignored, weak clocks", nw, 12);
        write_reg(8'h87, 8'hDF);
        run_cycle(0, 0, 0, 0, na, np, nw, ns, no);
        check(na == 2 && nw == 0, "R6", "bit5 clear with others set, ALE pulses", na, 2);

        // R10: reset clears the disable bit
        write_reg(8'h87, 8'h20);
        do_reset(1'b0);
        run_cycle(0, 0, 0, 0, na, np, nw, ns, no);
        check(na == 2 && nw == 0, "R10", "disable cleared by reset, ALE pulses", na, 2);

        // R9: short pulse ignored
        seen = 0;
        @(negedge osc_clk);
        rst_pin = 1'b1;
        repeat (16) begin @(negedge osc_clk); if (rst_int) seen++; end
        rst_pin = 1'b0;
        repeat (6) begin @(negedge osc_clk); if (rst_int) seen++; end
        check(seen == 0, "R9", "16-clock pulse, clocks with rst_int", seen, 0);

        // external execution
        do_reset(1'b1);
        strap_ext = 1'b0;
        run_cycle(0, 0, 0, 0, na, np, nw, ns, no);
        check(np == 2, "R4", "external PSEN activations", np, 2);
        check(np == 2, "R10", "strap change after reset ignored", np, 2);
        check(na == 2, "R2", "external ALE pulses", na, 2);
        check(no == 0, "R4", "ALE/PSEN overlap clocks", no, 0);
        run_cycle(1, 0, 0, 0, na, np, nw, ns, no);
        check(np == 0, "R5", "xdata cycle PSEN activations", np, 0);
        check(na == 1, "R3", "xdata cycle ALE pulses", na, 1);
        write_reg(8'h87, 8'h20);
        run_cycle(0, 0, 0, 0, na, np, nw, ns, no);
        check(na == 2, "R8", "disable under external execution, ALE pulses", na, 2);
        check(nw == 0, "R8", "disable under external execution, weak clocks", nw, 0);
        check(np == 2, "R8", "disable under external execution, PSEN", np, 2);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end
endmodule